// File: doc/BRIEF.md
# Reset Sequencing and Completion Status Controller

This block owns the reset behaviour of a small metering-style register file and the compute engine behind it. Two kinds of reset reach it: an external active-low reset pin, which must stay low for a minimum number of clock cycles to count, and a software request bit in the main configuration register. Either one opens a timed transition window of fixed length. When that window closes, the block raises a sticky completion flag and pulls an active-low interrupt line low. The two reset kinds clear different sets of registers. The pin restores every register. The software request leaves two retention registers alone and keeps a locked serial-port selection.

Firmware clears the completion flag by writing a one to its bit, which also releases the interrupt. The compute engine stays stopped after any reset. It starts only when firmware writes the start code to the run register. The software request is honoured only in the full power mode. A separate active-low power-on reset brings the whole block to its defaults at start-up. The pin goes through a two-flop synchronizer and a low-time counter, so a short glitch resets nothing.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After power-on reset, and after an accepted pin reset, every register reads its default: word 0 configuration 0x0000, word 1 retained configuration 0x0C00, word 2 retained low-power threshold 0x00FF, word 3 status 0x0000, word 4 run 0x0000, word 5 port selection 0x0000, word 6 gain 0x0400, word 7 reserved 0x0000. Also, irq_n is 1 and engine_run is 0.
- R2: A pin reset is accepted only if the synchronized pin was low for at least MIN_LOW_CYC consecutive cycles. The reset takes effect on the third rising clock edge after the pin returns high. A low pulse of MIN_LOW_CYC-1 cycles changes nothing.
- R3: In power mode 2'b00, writing word 0 with bit 7 set starts a software reset. Words 0, 4 and 6 return to their defaults, and words 1 and 2 keep their values.
- R4: In any power mode other than 2'b00, bit 7 of a word-0 write is stored as 0 and no transition starts. The other bits of the write are stored.
- R5: A transition lasts TRANS_CYC cycles from the accepting edge. During the transition, status bit 15 reads 0 and irq_n is 1. On the TRANS_CYC-th edge, bit 15 becomes 1 and irq_n becomes 0. During a software transition, word 0 bit 7 reads 1, and it clears when the transition ends.
- R6: Writing word 3 with bit 15 = 1 clears the completion flag and returns irq_n to 1. Writing word 3 with bit 15 = 0 leaves both unchanged.
- R7: engine_run is 1 only while word 4 holds 0x0001. Writing 0x0001 to word 4 starts the engine, any other value keeps it stopped, and every reset stops it.
- R8: While a transition is in progress, writes to any word other than 3 are ignored.
- R9: In word 5, bit 0 selects the alternate port (0 is the default port) and bit 1 is the lock. A pin reset clears word 5. A software reset keeps word 5 if the lock is set and clears it otherwise. Writes to word 5 are ignored while the lock is set.
- R10: Outside a transition, writes store their data into words 1, 2, 4 and 6 as written, into word 0 with bit 7 stripped, and into word 5 masked to bits 1:0. Reads return these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| rst_pin_n | input | 1 | External reset pin, asynchronous, active low |
| pwr_mode | input | 2 | Current power mode, 2'b00 = full operation |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 16 | Register read data, combinational from rd_addr |
| irq_n | output | 1 | Active-low completion interrupt |
| engine_run | output | 1 | Compute engine enable |

## Verification
The bench drives pin pulses exactly one cycle shorter than the minimum and exactly at the minimum. A design that miscounts the synchronizer delay or the low time would either reset on a glitch or ignore a legal reset. It samples the completion flag in the last cycle of the window and in the first cycle after it, which exposes an off-by-one transition length and an interrupt that fires early. It also separates the reset kinds: the retention words and a locked port selection must survive a software reset and fall to defaults on a pin reset. A request made in low-power mode must leave everything running, and a write during the window, or a write to a locked port, must not land.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NUM_SLOTS = 1 << AW;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] word_t;

  localparam addr_t A_CFG  = 3'd0;
  localparam addr_t A_KEEP = 3'd1;
  localparam addr_t A_LPTH = 3'd2;
  localparam addr_t A_STAT = 3'd3;
  localparam addr_t A_RUN  = 3'd4;
  localparam addr_t A_PORT = 3'd5;
  localparam addr_t A_GAIN = 3'd6;

  localparam int SWREQ_BIT = 7;
  localparam int DONE_BIT  = 15;
  localparam int LOCK_BIT  = 1;

  localparam word_t SWREQ_MASK = word_t'(1) << SWREQ_BIT;
  localparam word_t DONE_MASK  = word_t'(1) << DONE_BIT;
  localparam word_t PORT_MASK  = 16'h0003;
  localparam word_t RUN_CODE   = 16'h0001;

  localparam logic [1:0] MODE_FULL = 2'b00;

  typedef enum logic {PH_IDLE = 1'b0, PH_TRANS = 1'b1} phase_e;

  // Power-on / pin-reset value of each stored word.
  function automatic word_t reg_default(addr_t a);
    case (a)
      A_KEEP:  return 16'h0C00;
      A_LPTH:  return 16'h00FF;
      A_GAIN:  return 16'h0400;
      default: return '0;
    endcase
  endfunction

  // Value a word takes when a software reset is accepted.
  function automatic word_t soft_value(addr_t a, word_t cur);
    case (a)
      A_KEEP, A_LPTH: return cur;
      A_PORT:         return cur[LOCK_BIT] ? cur : reg_default(a);
      A_CFG:          return reg_default(a) | SWREQ_MASK;
      default:        return reg_default(a);
    endcase
  endfunction

  // Value a word takes on an ordinary accepted write.
  function automatic word_t store_value(addr_t a, word_t cur, word_t d);
    case (a)
      A_CFG:          return d & ~SWREQ_MASK;
      A_PORT:         return cur[LOCK_BIT] ? cur : (d & PORT_MASK);
      A_STAT, 3'd7:   return cur;
      default:        return d;
    endcase
  endfunction

  function automatic logic is_start_code(word_t d);
    return d == RUN_CODE;
  endfunction
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int MIN_LOW_CYC = 1250
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic hw_evt
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(MIN_LOW_CYC);

  logic [1:0]    sync_q;
  logic          pin_s;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_n};
  end

  assign pin_s = sync_q[1];

  // Counts consecutive synchronized low cycles, saturating at the minimum.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               low_cnt <= '0;
    else if (pin_s)           low_cnt <= '0;
    else if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
  end

  assign hw_evt = pin_s && (low_cnt == CNT_TOP);

  // R2: an accepted reset always follows a low synchronized pin
  a_r2_evt_after_low: assert property (@(posedge clk) disable iff (!por_n)
    hw_evt |-> !$past(pin_s));
  // R2: an accepted reset is a single-cycle event
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    hw_evt |=> !hw_evt);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm #(
  parameter int TRANS_CYC = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic stat_clr,
  output logic in_trans,
  output logic trans_end,
  output logic done_flag
);
  import rst_seq_pkg::*;

  localparam int TW = $clog2(TRANS_CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(TRANS_CYC - 1);

  phase_e        phase_q;
  logic [TW-1:0] cnt_q;

  assign in_trans  = (phase_q == PH_TRANS);
  assign trans_end = in_trans && (cnt_q == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      done_flag <= 1'b0;
    end else if (start) begin
      phase_q   <= PH_TRANS;
      cnt_q     <= LOAD;
      done_flag <= 1'b0;
    end else if (trans_end) begin
      phase_q   <= PH_IDLE;
      done_flag <= 1'b1;
    end else begin
      if (in_trans) cnt_q <= cnt_q - 1'b1;
      if (stat_clr) done_flag <= 1'b0;
    end
  end

  // R5: flag is never set while the window is open
  a_r5_flag_low_in_window: assert property (@(posedge clk) disable iff (!por_n)
    in_trans |-> !done_flag);
  // R5: flag rises only as the window closes
  a_r5_rise_at_end: assert property (@(posedge clk) disable iff (!por_n)
    $rose(done_flag) |-> $past(trans_end));
  // R6: a clearing write drops the flag
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!por_n)
    (stat_clr && !start && !trans_end) |=> !done_flag);
endmodule

// File: rtl/rst_reg_bank.sv
module rst_reg_bank (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     hw_evt,
  input  logic                     sw_go,
  input  logic                     trans_end,
  input  logic                     in_trans,
  input  logic                     done_flag,
  input  logic [1:0]               pwr_mode,
  input  logic                     wr_en,
  input  rst_seq_pkg::addr_t       wr_addr,
  input  rst_seq_pkg::word_t       wr_data,
  input  rst_seq_pkg::addr_t       rd_addr,
  output rst_seq_pkg::word_t       rd_data,
  output logic                     sw_req,
  output logic                     stat_clr,
  output logic                     engine_run
);
  import rst_seq_pkg::*;

  word_t q_arr [NUM_SLOTS];
  logic  wr_ok;

  assign wr_ok    = wr_en && !in_trans;
  assign sw_req   = wr_ok && (wr_addr == A_CFG) && wr_data[SWREQ_BIT] && (pwr_mode == MODE_FULL);
  assign stat_clr = wr_en && (wr_addr == A_STAT) && wr_data[DONE_BIT];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam addr_t SA = addr_t'(i);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                               q_arr[i] <= reg_default(SA);
      else if (hw_evt)                          q_arr[i] <= reg_default(SA);
      else if (sw_go)                           q_arr[i] <= soft_value(SA, q_arr[i]);
      else if (trans_end && SA == A_CFG)        q_arr[i] <= q_arr[i] & ~SWREQ_MASK;
      else if (wr_ok && wr_addr == SA)          q_arr[i] <= store_value(SA, q_arr[i], wr_data);
    end
  end

  assign rd_data    = (rd_addr == A_STAT) ? (done_flag ? DONE_MASK : '0) : q_arr[rd_addr];
  assign engine_run = is_start_code(q_arr[A_RUN]);

  // R7: engine starts only from a start-code write
  a_r7_start_by_write: assert property (@(posedge clk) disable iff (!por_n)
    $rose(engine_run) |-> $past(wr_en && wr_addr == A_RUN && wr_data == RUN_CODE));
  // R8: a plain register cannot change inside the window except by a pin reset
  a_r8_frozen_in_window: assert property (@(posedge clk) disable iff (!por_n)
    (in_trans && !hw_evt) |=> $stable(q_arr[A_GAIN]));
  // R3: retention words survive a software reset
  a_r3_keep_retained: assert property (@(posedge clk) disable iff (!por_n)
    (sw_go && !hw_evt) |=> ($stable(q_arr[A_KEEP]) && $stable(q_arr[A_LPTH])));
  // R9: a locked port selection only moves on a pin reset
  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!por_n)
    (q_arr[A_PORT][LOCK_BIT] && !hw_evt) |=> $stable(q_arr[A_PORT]));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int MIN_LOW_CYC = 1250,
  parameter int TRANS_CYC   = 64
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_pin_n,
  input  logic [1:0]  pwr_mode,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        irq_n,
  output logic        engine_run
);
  import rst_seq_pkg::*;

  logic hw_evt, sw_req, sw_go, stat_clr;
  logic in_trans, trans_end, done_flag;

  assign sw_go = sw_req && !hw_evt;

  rst_pin_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_pin (
    .clk(clk), .por_n(por_n), .pin_n(rst_pin_n), .hw_evt(hw_evt)
  );

  rst_seq_fsm #(.TRANS_CYC(TRANS_CYC)) u_fsm (
    .clk(clk), .por_n(por_n), .start(hw_evt || sw_go), .stat_clr(stat_clr),
    .in_trans(in_trans), .trans_end(trans_end), .done_flag(done_flag)
  );

  rst_reg_bank u_bank (
    .clk(clk), .por_n(por_n), .hw_evt(hw_evt), .sw_go(sw_go),
    .trans_end(trans_end), .in_trans(in_trans), .done_flag(done_flag),
    .pwr_mode(pwr_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sw_req(sw_req), .stat_clr(stat_clr),
    .engine_run(engine_run)
  );

  assign irq_n = !done_flag;

  // R4: a window opens only from a pin reset or a full-mode request
  a_r4_no_low_power_soft: assert property (@(posedge clk) disable iff (!por_n)
    $rose(in_trans) |-> ($past(hw_evt) || $past(pwr_mode) == MODE_FULL));
  // R5: interrupt asserts only as a window closes
  a_r5_irq_at_end: assert property (@(posedge clk) disable iff (!por_n)
    $fell(irq_n) |-> $past(trans_end));
endmodule

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;
  localparam int MINL = 1250;
  localparam int TL   = 64;

  logic        clk = 0;
  logic        por_n = 0;
  logic        rst_pin_n = 1;
  logic [1:0]  pwr_mode = 2'b00;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_n, engine_run;

  int n_chk = 0, n_bad = 0;
  logic [15:0] mdl [8];
  logic        mdl_done;

  always #4 clk = ~clk;

  rst_seq_ctrl #(.MIN_LOW_CYC(MINL), .TRANS_CYC(TL)) u_rst_seq_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .pwr_mode(pwr_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_n(irq_n), .engine_run(engine_run)
  );

  function automatic logic [15:0] dflt(int a);
    if (a == 1) return 16'h0C00;
    if (a == 2) return 16'h00FF;
    if (a == 6) return 16'h0400;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] after_write(int a, logic [15:0] cur, logic [15:0] d);
    if (a == 0) return {d[15:8], 1'b0, d[6:0]};
    if (a == 5) return cur[1] ? cur : {14'b0, d[1:0]};
    if (a == 3 || a == 7) return cur;
    return d;
  endfunction

  task automatic all_defaults();
    for (int a = 0; a < 8; a++) mdl[a] = dflt(a);
    mdl_done = 0;
  endtask

  task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, int a, logic [15:0] exp);
    rd_addr = a[2:0];
    #1;
    check16(tag, rd_data, exp);
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk);
    rst_pin_n = 0;
    repeat (n) @(negedge clk);
    rst_pin_n = 1;
  endtask

  task automatic check_model(string tag);
    for (int a = 0; a < 8; a++)
      rd(tag, a, (a == 3) ? {mdl_done, 15'b0} : mdl[a]);
    check16({tag, " irq"}, {15'b0, irq_n}, {15'b0, !mdl_done});
    check16({tag, " run"}, {15'b0, engine_run}, {15'b0, mdl[4] == 16'h0001});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    all_defaults();
    check_model("R1 power-on");

    // R7: wrong code keeps engine stopped, start code runs it
    wr(4, 16'h0002); mdl[4] = 16'h0002;
    check16("R7 wrong code", {15'b0, engine_run}, 16'h0);
    wr(4, 16'h0001); mdl[4] = 16'h0001;
    check16("R7 start code", {15'b0, engine_run}, 16'h1);

    // R10: ordinary stores
    wr(6, 16'h1234); mdl[6] = 16'h1234;
    wr(1, 16'hBEEF); mdl[1] = 16'hBEEF;
    wr(2, 16'h0042); mdl[2] = 16'h0042;
    wr(5, 16'hFFF1); mdl[5] = 16'h0001;
    wr(0, 16'h0011); mdl[0] = 16'h0011;
    check_model("R10 stores");

    // R3/R5/R8: software reset in full mode
    wr(0, 16'h0080);
    wr(6, 16'h5555);                       // R8: ignored inside window
    repeat (TL - 3) @(negedge clk);
    rd("R5 cfg bit set in window", 0, 16'h0080);
    rd("R5 flag low last window cycle", 3, 16'h0000);
    check16("R5 irq high in window", {15'b0, irq_n}, 16'h1);
    @(negedge clk);
    mdl[0] = 0; mdl[4] = 0; mdl[6] = dflt(6); mdl[5] = 0; mdl_done = 1;
    check_model("R3 R5 R8 R9 after soft reset");

    // R6: zero write keeps flag, one write clears it
    wr(3, 16'h7FFF);
    rd("R6 zero write no effect", 3, 16'h8000);
    check16("R6 irq still low", {15'b0, irq_n}, 16'h0);
    wr(3, 16'h8000); mdl_done = 0;
    rd("R6 clear", 3, 16'h0000);
    check16("R6 irq released", {15'b0, irq_n}, 16'h1);

    // R9: lock, then locked writes and soft reset keep selection
    wr(5, 16'h0003); mdl[5] = 16'h0003;
    wr(5, 16'h0000);
    rd("R9 locked write ignored", 5, 16'h0003);
    wr(0, 16'h0080);
    repeat (TL) @(negedge clk);
    mdl[0] = 0; mdl[6] = dflt(6); mdl_done = 1;
    check_model("R9 lock survives soft reset");
    wr(3, 16'h8000); mdl_done = 0;

    // R4: request in low-power mode is dropped
    wr(6, 16'h0777); mdl[6] = 16'h0777;
    pwr_mode = 2'b01;
    wr(0, 16'h0085); mdl[0] = 16'h0005;
    repeat (TL + 2) @(negedge clk);
    check_model("R4 low-power request");
    pwr_mode = 2'b11;
    wr(0, 16'h00A0); mdl[0] = 16'h0020;
    repeat (TL + 2) @(negedge clk);
    check_model("R4 mode 3 request");
    pwr_mode = 2'b00;

    // R2: short pulse ignored
    wr(4, 16'h0001); mdl[4] = 16'h0001;
    pulse(MINL - 1);
    repeat (TL + 6) @(negedge clk);
    check_model("R2 short pulse");

    // R1/R2: minimum pulse accepted, everything defaults
    pulse(MINL);
    repeat (2 + TL) @(negedge clk);
    rd("R2 flag low before end", 3, 16'h0000);
    @(negedge clk);
    all_defaults(); mdl_done = 1;
    check_model("R1 R2 pin reset");

    // Random traffic against the model (R6 R7 R10)
    for (int k = 0; k < 400; k++) begin
      int a;
      logic [15:0] d;
      a = $urandom_range(7);
      d = 16'($urandom);
      if (a == 4 && $urandom_range(3) == 0) d = 16'h0001;
      pwr_mode = 2'($urandom);
      if (a == 0 && pwr_mode == 2'b00) d[7] = 1'b0;
      wr(a, d);
      if (a == 3 && d[15]) mdl_done = 0;
      mdl[a] = after_write(a, mdl[a], d);
      rd("R10 random readback", a, (a == 3) ? {mdl_done, 15'b0} : mdl[a]);
      check16("R7 random run", {15'b0, engine_run}, {15'b0, mdl[4] == 16'h0001});
    end
    check_model("R6 R10 random end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule